// File: doc/BRIEF.md
# Byte FIFO with Register and Pseudo-DMA Access

This block is the byte-wide data buffer that sits between a host and a SCSI bus engine. It holds up to sixteen bytes in arrival order. The host can reach it in two ways. The first is a single-byte register port that pushes or pops one byte per access. The second is a pseudo-DMA port that takes 8-bit or 16-bit accesses. A 16-bit access is turned into two byte operations on consecutive cycles, with the more significant byte handled first.

An external transfer counter limits pseudo-DMA writes. The block sees only whether that counter is nonzero. For each byte it accepts, it returns a one-cycle decrement strobe. A fill-level output reports how many bytes are held. A flush input empties the buffer in one cycle.

Overflow and underflow are handled without error signalling. A byte pushed into a full buffer is lost. A pop from an empty buffer yields 0x00.

Top module: `scsi_data_fifo`

## Requirements
- R1: After reset the buffer is empty, `fill_level` is 0, `reg_rd_data` and `pd_rdata` are 0, and `pd_busy` and `pd_rvalid` are low.
- R2: Bytes leave in the order they entered. A `reg_rd` pulse pops the oldest byte, and that byte appears on `reg_rd_data` after the next rising edge.
- R3: A push while sixteen bytes are held is discarded. The count stays at 16 and the stored bytes are unchanged.
- R4: A pop while the buffer is empty returns 0x00 and the count stays 0. This applies to register reads and to every byte of a pseudo-DMA read.
- R5: `fill_level` bits 4:0 give the number of bytes held (0 to 16), and its upper bits are always 0.
- R6: A 16-bit pseudo-DMA write (`pd_wr` with `pd_wide`=1) offers `pd_wdata[15:8]` in the accept cycle and `pd_wdata[7:0]` in the next cycle. `pd_busy` is high during that second cycle, and `pd_wr`/`pd_rd` are ignored while it is high.
- R7: Each pseudo-DMA write byte is pushed only when `tc_nonzero` is 1 in its cycle. `dec_pulse` is high in exactly that cycle. When `tc_nonzero` is 0 the byte is dropped and `dec_pulse` stays low.
- R8: The count check is made per byte. If the counter reaches zero after the high byte of a 16-bit write, the low byte is dropped and no second `dec_pulse` is issued.
- R9: An 8-bit pseudo-DMA read gives `{8'h00, byte}` on `pd_rdata`, with `pd_rvalid` high one cycle after the accept cycle. A 16-bit read pops two bytes and gives `{first, second}`, with `pd_rvalid` high two cycles after the accept cycle.
- R10: `flush` empties the buffer at the next edge. It overrides any push or pop in the same cycle, and a register read in that cycle returns 0x00.
- R11: A push and a pop in the same cycle on a buffer that is neither empty nor full leave the count unchanged.
- R12: When the pseudo-DMA side pushes (or pops) a byte in a cycle, a register write (or read) in the same cycle does not reach the buffer. A register read that loses this contention returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Empty the buffer |
| reg_wr | input | 1 | Register-port push strobe |
| reg_wr_data | input | 8 | Register-port push byte |
| reg_rd | input | 1 | Register-port pop strobe |
| reg_rd_data | output | 8 | Last byte popped by the register port |
| fill_level | output | 8 | Number of bytes held, in bits 4:0 |
| pd_wr | input | 1 | Pseudo-DMA write request |
| pd_rd | input | 1 | Pseudo-DMA read request |
| pd_wide | input | 1 | 1 selects a 16-bit access, 0 an 8-bit access |
| pd_wdata | input | 16 | Pseudo-DMA write data (low byte used for 8-bit accesses) |
| tc_nonzero | input | 1 | External transfer count is nonzero |
| dec_pulse | output | 1 | Decrement strobe, one per accepted write byte |
| pd_busy | output | 1 | Second half of a 16-bit access in progress |
| pd_rdata | output | 16 | Pseudo-DMA read result |
| pd_rvalid | output | 1 | `pd_rdata` updated this cycle |

## Verification
The bench checks each corner case for the specific way a wrong design would fail:
- It fills the buffer to sixteen and pushes once more. A design with a wrapping write pointer would corrupt the oldest byte or roll the count over to zero.
- It pops an empty buffer. A design that fails here would return stale storage or underflow the count to 31.
- For 16-bit accesses, it checks that the high byte comes first in both directions. A byte-swapped design would reverse the order of the stored or returned data.
- It arms the counter with one before a 16-bit write. A design that checks the count only once per access would push both bytes and strobe twice.
- It drives flush together with a push, and a push together with a pop. A design with the wrong priority would leave a byte behind after the flush or drift the count.
- It drives both ports in the same cycle. A design without arbitration would corrupt a byte or lose track of the count.

// File: rtl/sdf_pkg.sv
package sdf_pkg;

    typedef enum logic {
        SEQ_IDLE   = 1'b0,
        SEQ_SECOND = 1'b1
    } seq_phase_e;

    typedef enum logic {
        SEQ_DIR_WR = 1'b0,
        SEQ_DIR_RD = 1'b1
    } seq_dir_e;

endpackage

// File: rtl/sdf_store.sv
module sdf_store #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 8,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = AW + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] head_data,
    output logic [CW-1:0]    count
);

    typedef struct packed {
        logic [DEPTH-1:0][WIDTH-1:0] mem;
        logic [AW-1:0]               wr_ptr;
        logic [AW-1:0]               rd_ptr;
        logic [CW-1:0]               cnt;
    } store_t;

    store_t st_d, st_q;
    logic   push_ok, pop_ok;

    function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        st_d    = st_q;
        push_ok = push && (st_q.cnt != CW'(DEPTH));
        pop_ok  = pop && (st_q.cnt != '0);
        if (flush) begin
            st_d.wr_ptr = '0;
            st_d.rd_ptr = '0;
            st_d.cnt    = '0;
        end else begin
            if (push_ok) begin
                st_d.mem[st_q.wr_ptr] = push_data;
                st_d.wr_ptr           = ptr_next(st_q.wr_ptr);
            end
            if (pop_ok) begin
                st_d.rd_ptr = ptr_next(st_q.rd_ptr);
            end
            case ({push_ok, pop_ok})
                2'b10:   st_d.cnt = st_q.cnt + 1'b1;
                2'b01:   st_d.cnt = st_q.cnt - 1'b1;
                default: st_d.cnt = st_q.cnt;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign head_data = (st_q.cnt != '0) ? st_q.mem[st_q.rd_ptr] : '0;
    assign count     = st_q.cnt;

endmodule

// File: rtl/sdf_pdma_seq.sv
module sdf_pdma_seq
    import sdf_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            pd_wr,
    input  logic            pd_rd,
    input  logic            pd_wide,
    input  logic [2*DW-1:0] pd_wdata,
    input  logic            tc_nonzero,
    input  logic [DW-1:0]   head_data,
    output logic            byte_push,
    output logic [DW-1:0]   byte_push_data,
    output logic            byte_pop,
    output logic            pd_busy,
    output logic [2*DW-1:0] pd_rdata,
    output logic            pd_rvalid
);

    typedef struct packed {
        seq_phase_e      phase;
        seq_dir_e        dir;
        logic [DW-1:0]   hold;
        logic [2*DW-1:0] rdata;
        logic            rvalid;
    } seq_t;

    seq_t sq_d, sq_q;

    always_comb begin
        sq_d           = sq_q;
        sq_d.rvalid    = 1'b0;
        byte_push      = 1'b0;
        byte_push_data = '0;
        byte_pop       = 1'b0;
        if (sq_q.phase == SEQ_SECOND) begin
            sq_d.phase = SEQ_IDLE;
            if (sq_q.dir == SEQ_DIR_WR) begin
                byte_push_data = sq_q.hold;
                byte_push      = tc_nonzero;
            end else begin
                byte_pop    = 1'b1;
                sq_d.rdata  = {sq_q.hold, head_data};
                sq_d.rvalid = 1'b1;
            end
        end else if (pd_wr) begin
            byte_push_data = pd_wide ? pd_wdata[2*DW-1:DW] : pd_wdata[DW-1:0];
            byte_push      = tc_nonzero;
            if (pd_wide) begin
                sq_d.phase = SEQ_SECOND;
                sq_d.dir   = SEQ_DIR_WR;
                sq_d.hold  = pd_wdata[DW-1:0];
            end
        end else if (pd_rd) begin
            byte_pop = 1'b1;
            if (pd_wide) begin
                sq_d.phase = SEQ_SECOND;
                sq_d.dir   = SEQ_DIR_RD;
                sq_d.hold  = head_data;
            end else begin
                sq_d.rdata  = {{DW{1'b0}}, head_data};
                sq_d.rvalid = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sq_q <= '{phase: SEQ_IDLE, dir: SEQ_DIR_WR, hold: '0, rdata: '0, rvalid: 1'b0};
        end else begin
            sq_q <= sq_d;
        end
    end

    assign pd_busy   = (sq_q.phase == SEQ_SECOND);
    assign pd_rdata  = sq_q.rdata;
    assign pd_rvalid = sq_q.rvalid;

endmodule

// File: rtl/scsi_data_fifo.sv
module scsi_data_fifo #(
    parameter int DEPTH  = 16,
    parameter int DW     = 8,
    parameter int FLAG_W = 8,
    localparam int CW    = $clog2(DEPTH) + 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            flush,
    input  logic            reg_wr,
    input  logic [DW-1:0]   reg_wr_data,
    input  logic            reg_rd,
    output logic [DW-1:0]   reg_rd_data,
    output logic [FLAG_W-1:0] fill_level,
    input  logic            pd_wr,
    input  logic            pd_rd,
    input  logic            pd_wide,
    input  logic [2*DW-1:0] pd_wdata,
    input  logic            tc_nonzero,
    output logic            dec_pulse,
    output logic            pd_busy,
    output logic [2*DW-1:0] pd_rdata,
    output logic            pd_rvalid
);

    logic [DW-1:0] core_head, head_seen;
    logic [CW-1:0] core_count;
    logic          seq_push, seq_pop;
    logic [DW-1:0] seq_push_data;
    logic          core_push, core_pop;
    logic [DW-1:0] core_push_data;

    typedef struct packed {
        logic [DW-1:0] rd_byte;
    } port_t;

    port_t pt_d, pt_q;

    assign head_seen = flush ? '0 : core_head;

    sdf_pdma_seq #(.DW(DW)) u_seq (
        .clk            (clk),
        .rst_n          (rst_n),
        .pd_wr          (pd_wr),
        .pd_rd          (pd_rd),
        .pd_wide        (pd_wide),
        .pd_wdata       (pd_wdata),
        .tc_nonzero     (tc_nonzero),
        .head_data      (head_seen),
        .byte_push      (seq_push),
        .byte_push_data (seq_push_data),
        .byte_pop       (seq_pop),
        .pd_busy        (pd_busy),
        .pd_rdata       (pd_rdata),
        .pd_rvalid      (pd_rvalid)
    );

    always_comb begin
        core_push      = seq_push | reg_wr;
        core_push_data = seq_push ? seq_push_data : reg_wr_data;
        core_pop       = seq_pop | reg_rd;
        pt_d           = pt_q;
        if (reg_rd) begin
            pt_d.rd_byte = seq_pop ? '0 : head_seen;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pt_q <= '0;
        end else begin
            pt_q <= pt_d;
        end
    end

    sdf_store #(.DEPTH(DEPTH), .WIDTH(DW)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush),
        .push      (core_push),
        .push_data (core_push_data),
        .pop       (core_pop),
        .head_data (core_head),
        .count     (core_count)
    );

    assign reg_rd_data = pt_q.rd_byte;
    assign fill_level  = FLAG_W'(core_count);
    assign dec_pulse   = seq_push;

endmodule

// File: rtl/scsi_data_fifo_chk.sv
module scsi_data_fifo_chk #(
    parameter int DEPTH  = 16,
    parameter int DW     = 8,
    parameter int FLAG_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              flush,
    input logic              reg_rd,
    input logic              pd_rd,
    input logic              pd_busy,
    input logic              tc_nonzero,
    input logic              dec_pulse,
    input logic [FLAG_W-1:0] fill_level,
    input logic [DW-1:0]     reg_rd_data
);

    p_level_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        fill_level <= FLAG_W'(DEPTH));

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_level == FLAG_W'(DEPTH) && !reg_rd && !pd_rd && !pd_busy && !flush)
        |=> fill_level == FLAG_W'(DEPTH));

    p_empty_pop_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_level == '0 && reg_rd && !pd_rd && !pd_busy) |=> reg_rd_data == '0);

    p_flush_empties_r10: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> fill_level == '0);

    p_dec_needs_count_r7: assert property (@(posedge clk) disable iff (!rst_n)
        dec_pulse |-> tc_nonzero);

    p_second_half_once_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pd_busy |=> !pd_busy);

endmodule

bind scsi_data_fifo scsi_data_fifo_chk #(.DEPTH(DEPTH), .DW(DW), .FLAG_W(FLAG_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .flush       (flush),
    .reg_rd      (reg_rd),
    .pd_rd       (pd_rd),
    .pd_busy     (pd_busy),
    .tc_nonzero  (tc_nonzero),
    .dec_pulse   (dec_pulse),
    .fill_level  (fill_level),
    .reg_rd_data (reg_rd_data)
);

// File: tb/scsi_data_fifo_test.sv
module scsi_data_fifo_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flush = 1'b0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_wr_data = '0;
    logic        reg_rd = 1'b0;
    logic [7:0]  reg_rd_data;
    logic [7:0]  fill_level;
    logic        pd_wr = 1'b0;
    logic        pd_rd = 1'b0;
    logic        pd_wide = 1'b0;
    logic [15:0] pd_wdata = '0;
    logic        tc_nonzero;
    logic        dec_pulse;
    logic        pd_busy;
    logic [15:0] pd_rdata;
    logic        pd_rvalid;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [15:0] tc_cnt = '0;
    logic        tc_load = 1'b0;
    logic [15:0] tc_load_val = '0;

    always #10 clk = ~clk;

    assign tc_nonzero = (tc_cnt != 16'd0);

    always @(posedge clk) begin
        if (tc_load) tc_cnt <= tc_load_val;
        else if (dec_pulse) tc_cnt <= tc_cnt - 16'd1;
    end

    scsi_data_fifo uut (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .reg_wr(reg_wr), .reg_wr_data(reg_wr_data), .reg_rd(reg_rd),
        .reg_rd_data(reg_rd_data), .fill_level(fill_level),
        .pd_wr(pd_wr), .pd_rd(pd_rd), .pd_wide(pd_wide), .pd_wdata(pd_wdata),
        .tc_nonzero(tc_nonzero), .dec_pulse(dec_pulse), .pd_busy(pd_busy),
        .pd_rdata(pd_rdata), .pd_rvalid(pd_rvalid)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic set_tc(input logic [15:0] v);
        @(negedge clk); tc_load = 1'b1; tc_load_val = v;
        @(negedge clk); tc_load = 1'b0;
    endtask

    task automatic rpush(input logic [7:0] b);
        @(negedge clk); reg_wr = 1'b1; reg_wr_data = b;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic rpop_chk(input string req, input logic [7:0] exp);
        @(negedge clk); reg_rd = 1'b1;
        @(negedge clk); reg_rd = 1'b0;
        chk(req, {8'h00, reg_rd_data}, {8'h00, exp});
    endtask

    task automatic test_reset();
        chk("R1 level", {8'h00, fill_level}, 16'h0000);
        chk("R1 reg data", {8'h00, reg_rd_data}, 16'h0000);
        chk("R1 pd data", pd_rdata, 16'h0000);
        chk("R1 busy/valid", {14'h0, pd_busy, pd_rvalid}, 16'h0000);
    endtask

    task automatic test_order();
        rpush(8'h11); rpush(8'h22); rpush(8'h33);
        chk("R5 level three", {8'h00, fill_level}, 16'h0003);
        rpop_chk("R2 first", 8'h11);
        rpop_chk("R2 second", 8'h22);
        rpop_chk("R2 third", 8'h33);
        chk("R5 level zero", {8'h00, fill_level}, 16'h0000);
    endtask

    task automatic test_empty_pop();
        rpop_chk("R4 empty pop", 8'h00);
        chk("R4 level stays", {8'h00, fill_level}, 16'h0000);
    endtask

    task automatic test_full();
        for (int i = 0; i < 16; i++) rpush(8'h40 + 8'(i));
        chk("R5 level sixteen", {8'h00, fill_level}, 16'h0010);
        rpush(8'hEE);
        chk("R3 level after overflow", {8'h00, fill_level}, 16'h0010);
        for (int i = 0; i < 16; i++) rpop_chk("R3 contents kept", 8'h40 + 8'(i));
        chk("R3 drained", {8'h00, fill_level}, 16'h0000);
    endtask

    task automatic test_pd_write16();
        set_tc(16'd5);
        @(negedge clk); pd_wr = 1'b1; pd_wide = 1'b1; pd_wdata = 16'hA1B2;
        #1 chk("R7 dec first byte", {15'h0, dec_pulse}, 16'h0001);
        @(negedge clk); pd_wr = 1'b0; pd_wide = 1'b0;
        #1 chk("R6 busy second cycle", {15'h0, pd_busy}, 16'h0001);
        chk("R7 dec second byte", {15'h0, dec_pulse}, 16'h0001);
        @(negedge clk);
        chk("R6 busy cleared", {15'h0, pd_busy}, 16'h0000);
        chk("R6 level two", {8'h00, fill_level}, 16'h0002);
        chk("R7 count decremented", tc_cnt, 16'd3);
        rpop_chk("R6 high byte first", 8'hA1);
        rpop_chk("R6 low byte second", 8'hB2);
    endtask

    task automatic test_tc_zero();
        set_tc(16'd0);
        @(negedge clk); pd_wr = 1'b1; pd_wdata = 16'h0055;
        #1 chk("R7 no dec at zero", {15'h0, dec_pulse}, 16'h0000);
        @(negedge clk); pd_wr = 1'b0;
        chk("R7 byte ignored", {8'h00, fill_level}, 16'h0000);
    endtask

    task automatic test_tc_edge();
        set_tc(16'd1);
        @(negedge clk); pd_wr = 1'b1; pd_wide = 1'b1; pd_wdata = 16'h1234;
        #1 chk("R8 first byte dec", {15'h0, dec_pulse}, 16'h0001);
        @(negedge clk); pd_wr = 1'b0; pd_wide = 1'b0;
        #1 chk("R8 second byte no dec", {15'h0, dec_pulse}, 16'h0000);
        @(negedge clk);
        chk("R8 only one byte", {8'h00, fill_level}, 16'h0001);
        chk("R8 count zero", tc_cnt, 16'd0);
        rpop_chk("R8 kept high byte", 8'h12);
    endtask

    task automatic test_pd_read();
        rpush(8'h9A); rpush(8'hBC); rpush(8'hDE);
        @(negedge clk); pd_rd = 1'b1; pd_wide = 1'b1;
        @(negedge clk); pd_rd = 1'b0; pd_wide = 1'b0;
        chk("R9 no valid yet", {15'h0, pd_rvalid}, 16'h0000);
        @(negedge clk);
        chk("R9 wide valid", {15'h0, pd_rvalid}, 16'h0001);
        chk("R9 wide data", pd_rdata, 16'h9ABC);
        @(negedge clk); pd_rd = 1'b1;
        @(negedge clk); pd_rd = 1'b0;
        chk("R9 narrow valid", {15'h0, pd_rvalid}, 16'h0001);
        chk("R9 narrow data", pd_rdata, 16'h00DE);
        chk("R9 level zero", {8'h00, fill_level}, 16'h0000);
        @(negedge clk); pd_rd = 1'b1; pd_wide = 1'b1;
        @(negedge clk); pd_rd = 1'b0; pd_wide = 1'b0;
        @(negedge clk);
        chk("R4 wide read empty", pd_rdata, 16'h0000);
    endtask

    task automatic test_flush();
        rpush(8'h01); rpush(8'h02); rpush(8'h03);
        @(negedge clk); flush = 1'b1; reg_wr = 1'b1; reg_wr_data = 8'h99;
        @(negedge clk); flush = 1'b0; reg_wr = 1'b0;
        chk("R10 empty after flush", {8'h00, fill_level}, 16'h0000);
        rpop_chk("R10 nothing left", 8'h00);
    endtask

    task automatic test_simul();
        rpush(8'h61); rpush(8'h62);
        @(negedge clk); reg_wr = 1'b1; reg_wr_data = 8'h63; reg_rd = 1'b1;
        @(negedge clk); reg_wr = 1'b0; reg_rd = 1'b0;
        chk("R11 level unchanged", {8'h00, fill_level}, 16'h0002);
        chk("R11 popped oldest", {8'h00, reg_rd_data}, 16'h0061);
        rpop_chk("R11 order a", 8'h62);
        rpop_chk("R11 order b", 8'h63);
    endtask

    task automatic test_collision();
        set_tc(16'd4);
        @(negedge clk); pd_wr = 1'b1; pd_wdata = 16'h00C3; reg_wr = 1'b1; reg_wr_data = 8'h3C;
        @(negedge clk); pd_wr = 1'b0; reg_wr = 1'b0;
        chk("R12 one byte stored", {8'h00, fill_level}, 16'h0001);
        rpop_chk("R12 pseudo-DMA byte kept", 8'hC3);
        rpush(8'hAA);
        @(negedge clk); pd_rd = 1'b1; reg_rd = 1'b1;
        @(negedge clk); pd_rd = 1'b0; reg_rd = 1'b0;
        chk("R12 register read loses", {8'h00, reg_rd_data}, 16'h0000);
        chk("R12 pseudo-DMA read wins", pd_rdata, 16'h00AA);
        chk("R12 level zero", {8'h00, fill_level}, 16'h0000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        test_reset();
        rst_n = 1'b1;
        test_order();
        test_empty_pop();
        test_full();
        test_pd_write16();
        test_tc_zero();
        test_tc_edge();
        test_pd_read();
        test_flush();
        test_simul();
        test_collision();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule